// File: doc/BRIEF.md
# Reloading Down-Counter Timer

This block is a memory-mapped countdown timer with one bank of four word registers. They hold the reload value, the live count, the control word and an interrupt clear. The counter width is a parameter: 16 bits for the small instances and 32 bits for the wide one. While the timer is enabled, the counter steps down by one on each pulse of the selected tick strobe. Two strobes come in as inputs, a fast one and a slow one, and a control bit chooses between them.

The counter underflows when a tick arrives while it holds zero. In periodic mode it then takes the reload value again. In free-running mode it wraps to all ones. Each underflow raises a level interrupt, which stays high until software writes anything to the clear register. The bus port is a single-cycle select/write strobe with registered read data. Software typically works in three steps: disable the timer, write the reload value (this also presets the counter), then enable it.

Top module: `countdown_timer`

## Requirements
- R1: After synchronous reset the load, value and control registers read 0, `irq` is 0 and `bus_rdata` is 0.
- R2: Register word offsets are 0x0 reload, 0x4 live count, 0x8 control, 0xC interrupt clear. Read data is registered: it appears the cycle after a read strobe and holds until the next read. The control word reads back only bit 7 (enable), bit 6 (periodic) and bit 3 (fast tick select), with all other bits 0. The clear offset reads 0.
- R3: A write to 0x0 updates the reload value. While enable is 0 it also sets the counter to the written value. While enable is 1 the counter is untouched.
- R4: While enable is 1, each selected tick lowers a nonzero count by exactly one. While enable is 0, ticks leave the count unchanged.
- R5: Control bit 3 = 1 selects `tick_fast` and bit 3 = 0 selects `tick_slow`. The unselected strobe has no effect.
- R6: In periodic mode (bit 6 = 1), a tick at count 0 reloads the reload value and sets `irq`. Reaching 0 by itself does not set `irq`.
- R7: In free-running mode (bit 6 = 0), a tick at count 0 wraps the count to all ones (CNT_W bits) and sets `irq`.
- R8: `irq` stays at 1 until a write of any data to 0xC. If an underflow happens in the same cycle as that write, `irq` stays 1.
- R9: The count register at 0x4 is read-only; writes to it change nothing.
- R10: A control write takes effect from the following cycle: a tick in the same cycle as the write uses the old settings. A zero control word stops counting and keeps the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe, one cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| tick_fast | input | 1 | Fast tick strobe |
| tick_slow | input | 1 | Slow tick strobe |
| irq | output | 1 | Level underflow interrupt |

## Verification
The bench runs the counter down to zero and checks two things: that arriving at zero does not fire the interrupt, and that only the next tick does. A design that underflows one tick early fails here. It also checks the free-running wrap to all ones, which a design that always reloads gets wrong. Two same-cycle collisions are driven: a clear write against an underflow, where a wrong design loses the event, and a disable write against a tick, where a wrong design drops the tick. Further checks cover a reload-value write to an enabled timer, which a wrong design uses to corrupt the live count, and the unselected tick strobe, which a wrong mux lets through.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam logic [3:0] OFS_LOAD  = 4'h0;
  localparam logic [3:0] OFS_VALUE = 4'h4;
  localparam logic [3:0] OFS_CTRL  = 4'h8;
  localparam logic [3:0] OFS_CLEAR = 4'hC;

  localparam int CTRL_EN_BIT   = 7;
  localparam int CTRL_PER_BIT  = 6;
  localparam int CTRL_FAST_BIT = 3;

  typedef enum logic [1:0] {
    REG_LOAD  = 2'd0,
    REG_VALUE = 2'd1,
    REG_CTRL  = 2'd2,
    REG_CLEAR = 2'd3
  } tmr_reg_e;

  typedef struct packed {
    logic en;
    logic periodic;
    logic fast;
  } tmr_ctrl_t;
endpackage

// File: rtl/tmr_decode.sv
module tmr_decode #(
  parameter int ADDR_W = 4
) (
  input  logic                    bus_sel,
  input  logic                    bus_wr,
  input  logic [ADDR_W-1:0]       bus_addr,
  output logic                    wr_load,
  output logic                    wr_ctrl,
  output logic                    wr_clear,
  output logic                    rd_en,
  output logic                    rd_hit,
  output timer_pkg::tmr_reg_e     rd_idx
);
  import timer_pkg::*;

  logic in_range;
  tmr_reg_e idx;

  // Only the low nibble addresses the bank; anything above it misses.
  assign in_range = ((bus_addr >> 4) == '0);
  assign idx      = tmr_reg_e'(bus_addr[3:2]);

  always_comb begin
    wr_load  = 1'b0;
    wr_ctrl  = 1'b0;
    wr_clear = 1'b0;
    if (bus_sel && bus_wr && in_range) begin
      unique case (idx)
        REG_LOAD:  wr_load  = 1'b1;
        REG_CTRL:  wr_ctrl  = 1'b1;
        REG_CLEAR: wr_clear = 1'b1;
        default:   ;
      endcase
    end
  end

  assign rd_en  = bus_sel && !bus_wr;
  assign rd_hit = in_range;
  assign rd_idx = idx;
endmodule

// File: rtl/tmr_cfg_regs.sv
module tmr_cfg_regs #(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_load,
  input  logic                  wr_ctrl,
  input  logic [DATA_W-1:0]     wdata,
  output logic [CNT_W-1:0]      load_q,
  output timer_pkg::tmr_ctrl_t  ctrl_q
);
  import timer_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      load_q <= '0;
      ctrl_q <= '0;
    end else begin
      if (wr_load) load_q <= wdata[CNT_W-1:0];
      if (wr_ctrl) begin
        ctrl_q.en       <= wdata[CTRL_EN_BIT];
        ctrl_q.periodic <= wdata[CTRL_PER_BIT];
        ctrl_q.fast     <= wdata[CTRL_FAST_BIT];
      end
    end
  end
endmodule

// File: rtl/tmr_tick_sel.sv
module tmr_tick_sel (
  input  logic fast_sel,
  input  logic tick_fast,
  input  logic tick_slow,
  output logic tick_pick
);
  assign tick_pick = fast_sel ? tick_fast : tick_slow;
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             periodic,
  input  logic             tick,
  input  logic             preset,
  input  logic [CNT_W-1:0] preset_val,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             irq_clr,
  output logic [CNT_W-1:0] count_q,
  output logic             irq_q
);
  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  logic step;
  logic under;
  logic [CNT_W-1:0] next_after_under;

  assign step  = en && tick;
  assign under = step && (count_q == '0);

  generate
    if (CNT_W > 0) begin : g_wrap
      assign next_after_under = periodic ? reload_val : ALL_ONES;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (preset && !en)  count_q <= preset_val;
      else if (under)     count_q <= next_after_under;
      else if (step)      count_q <= count_q - 1'b1;

      // A fresh underflow outranks a clear in the same cycle.
      if (under)          irq_q <= 1'b1;
      else if (irq_clr)   irq_q <= 1'b0;
    end
  end
endmodule

// File: rtl/countdown_timer.sv
module countdown_timer #(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tick_fast,
  input  logic              tick_slow,
  output logic              irq
);
  import timer_pkg::*;

  logic wr_load, wr_ctrl, wr_clear, rd_en, rd_hit;
  tmr_reg_e rd_idx;
  logic [CNT_W-1:0] load_q;
  logic [CNT_W-1:0] count_q;
  tmr_ctrl_t ctrl_q;
  logic ctrl_en, ctrl_per, ctrl_fast;
  logic tick_pick;
  logic [DATA_W-1:0] ctrl_word;

  assign ctrl_en   = ctrl_q.en;
  assign ctrl_per  = ctrl_q.periodic;
  assign ctrl_fast = ctrl_q.fast;

  tmr_decode #(.ADDR_W(ADDR_W)) u_decode (
    .bus_sel (bus_sel),
    .bus_wr  (bus_wr),
    .bus_addr(bus_addr),
    .wr_load (wr_load),
    .wr_ctrl (wr_ctrl),
    .wr_clear(wr_clear),
    .rd_en   (rd_en),
    .rd_hit  (rd_hit),
    .rd_idx  (rd_idx)
  );

  tmr_cfg_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_cfg (
    .clk    (clk),
    .rst    (rst),
    .wr_load(wr_load),
    .wr_ctrl(wr_ctrl),
    .wdata  (bus_wdata),
    .load_q (load_q),
    .ctrl_q (ctrl_q)
  );

  tmr_tick_sel u_tick (
    .fast_sel (ctrl_fast),
    .tick_fast(tick_fast),
    .tick_slow(tick_slow),
    .tick_pick(tick_pick)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .en        (ctrl_en),
    .periodic  (ctrl_per),
    .tick      (tick_pick),
    .preset    (wr_load),
    .preset_val(bus_wdata[CNT_W-1:0]),
    .reload_val(load_q),
    .irq_clr   (wr_clear),
    .count_q   (count_q),
    .irq_q     (irq)
  );

  always_comb begin
    ctrl_word = '0;
    ctrl_word[CTRL_EN_BIT]   = ctrl_en;
    ctrl_word[CTRL_PER_BIT]  = ctrl_per;
    ctrl_word[CTRL_FAST_BIT] = ctrl_fast;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (rd_en) begin
      if (!rd_hit) bus_rdata <= '0;
      else begin
        unique case (rd_idx)
          REG_LOAD:  bus_rdata <= DATA_W'(load_q);
          REG_VALUE: bus_rdata <= DATA_W'(count_q);
          REG_CTRL:  bus_rdata <= ctrl_word;
          default:   bus_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq,
  input logic [CNT_W-1:0]  count,
  input logic [CNT_W-1:0]  reload,
  input logic              en,
  input logic              per,
  input logic              tick_pick
);
  logic hit, clr_w, load_w;
  assign hit    = en && tick_pick;
  assign clr_w  = bus_sel && bus_wr && (bus_addr == ADDR_W'(12));
  assign load_w = bus_sel && bus_wr && (bus_addr == ADDR_W'(0));

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (!irq && bus_rdata == '0 && count == '0));

  assert_step_R4: assert property (@(posedge clk) disable iff (rst)
    (hit && count != '0) |=> (count == $past(count) - 1'b1));

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!hit && !(load_w && !en)) |=> $stable(count));

  assert_reload_R6: assert property (@(posedge clk) disable iff (rst)
    (hit && count == '0 && per) |=> (count == $past(reload) && irq));

  assert_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    (hit && count == '0 && !per) |=> (count == '1 && irq));

  assert_irq_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (irq && !clr_w) |=> irq);

  assert_irq_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (clr_w && !(hit && count == '0)) |=> !irq);
endmodule

bind countdown_timer tmr_checker #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_sel  (bus_sel),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_rdata(bus_rdata),
  .irq      (irq),
  .count    (count_q),
  .reload   (load_q),
  .en       (ctrl_en),
  .per      (ctrl_per),
  .tick_pick(tick_pick)
);

// File: tb/test_countdown_timer.sv
module test_countdown_timer;
  localparam int CNT_W  = 16;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic tick_fast = 1'b0, tick_slow = 1'b0;
  logic irq;
  int n_tests = 0, n_fail = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  countdown_timer #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_countdown_timer (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_fast(tick_fast),
    .tick_slow(tick_slow), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse(input bit fast, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (fast) tick_fast = 1'b1; else tick_slow = 1'b1;
      @(negedge clk);
      tick_fast = 1'b0; tick_slow = 1'b0;
    end
  endtask

  // Tick and register write land on the same clock edge.
  task automatic wr_with_tick(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; tick_fast = 1'b1;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; tick_fast = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 rdata", bus_rdata, 32'd0);
    rd_reg(4'h0, d); chk("R1 load", d, 32'd0);
    rd_reg(4'h4, d); chk("R1 value", d, 32'd0);
    rd_reg(4'h8, d); chk("R1 ctrl", d, 32'd0);
  endtask

  task automatic t_regmap;
    logic [31:0] d;
    wr_reg(4'h8, 32'hFFFF_FFFF);
    rd_reg(4'h8, d); chk("R2 ctrl readback", d, 32'h0000_00C8);
    wr_reg(4'h8, 32'h0);
    rd_reg(4'hC, d); chk("R2 clear reads 0", d, 32'd0);
  endtask

  task automatic t_preset;
    logic [31:0] d;
    wr_reg(4'h0, 32'hABCD_0005);
    rd_reg(4'h0, d); chk("R3 load reg", d, 32'h5);
    rd_reg(4'h4, d); chk("R3 preset value", d, 32'h5);
  endtask

  task automatic t_fast_count;
    logic [31:0] d;
    wr_reg(4'h8, 32'h88);
    pulse(1, 3);
    rd_reg(4'h4, d); chk("R4 decrement", d, 32'h2);
    pulse(0, 2);
    rd_reg(4'h4, d); chk("R5 slow ignored", d, 32'h2);
  endtask

  task automatic t_slow_count;
    logic [31:0] d;
    wr_reg(4'h8, 32'h80);
    pulse(0, 1);
    rd_reg(4'h4, d); chk("R5 slow counts", d, 32'h1);
    pulse(1, 2);
    rd_reg(4'h4, d); chk("R5 fast ignored", d, 32'h1);
  endtask

  task automatic t_disable;
    logic [31:0] d;
    wr_reg(4'h8, 32'h0);
    pulse(1, 2); pulse(0, 2);
    rd_reg(4'h4, d); chk("R10 zero ctrl stops", d, 32'h1);
  endtask

  task automatic t_load_enabled;
    logic [31:0] d;
    wr_reg(4'h8, 32'h88);
    wr_reg(4'h0, 32'h9);
    rd_reg(4'h4, d); chk("R3 enabled count untouched", d, 32'h1);
    rd_reg(4'h0, d); chk("R3 enabled load stored", d, 32'h9);
  endtask

  task automatic t_latency_and_zero;
    logic [31:0] d;
    rd_reg(4'h4, d);
    pulse(1, 1);
    chk("R2 rdata held", bus_rdata, 32'h1);
    chk("R6 zero no irq", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_periodic;
    logic [31:0] d;
    wr_reg(4'h8, 32'hC8);
    pulse(1, 1);
    chk("R6 irq on underflow", {31'd0, irq}, 32'd1);
    rd_reg(4'h4, d); chk("R6 reload", d, 32'h9);
  endtask

  task automatic t_irq_hold;
    logic [31:0] d;
    pulse(1, 2);
    rd_reg(4'h8, d);
    chk("R8 irq held", {31'd0, irq}, 32'd1);
    rd_reg(4'h4, d); chk("R6 periodic continues", d, 32'h7);
    wr_reg(4'hC, 32'h0);
    chk("R8 clear any data", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_free;
    logic [31:0] d;
    wr_reg(4'h8, 32'h0);
    wr_reg(4'h0, 32'h1);
    wr_reg(4'h8, 32'h88);
    pulse(1, 2);
    chk("R7 irq", {31'd0, irq}, 32'd1);
    rd_reg(4'h4, d); chk("R7 wrap all ones", d, 32'h0000_FFFF);
    wr_reg(4'hC, 32'h5A);
    chk("R8 clear", {31'd0, irq}, 32'd0);
    pulse(1, 1);
    rd_reg(4'h4, d); chk("R7 after wrap", d, 32'h0000_FFFE);
  endtask

  task automatic t_readonly;
    logic [31:0] d;
    wr_reg(4'h8, 32'h0);
    wr_reg(4'h4, 32'h1234);
    rd_reg(4'h4, d); chk("R9 value read-only", d, 32'h0000_FFFE);
    rd_reg(4'h0, d); chk("R9 load unaffected", d, 32'h1);
  endtask

  task automatic t_clear_race;
    logic [31:0] d;
    wr_reg(4'h0, 32'h0);
    wr_reg(4'h8, 32'hC8);
    wr_with_tick(4'hC, 32'h0);
    chk("R8 underflow beats clear", {31'd0, irq}, 32'd1);
    wr_reg(4'hC, 32'h0);
    chk("R8 later clear", {31'd0, irq}, 32'd0);
    rd_reg(4'h4, d); chk("R6 reload zero", d, 32'h0);
  endtask

  task automatic t_ctrl_timing;
    logic [31:0] d;
    wr_reg(4'h8, 32'h0);
    wr_reg(4'h0, 32'h4);
    wr_reg(4'h8, 32'h88);
    wr_with_tick(4'h8, 32'h0);
    rd_reg(4'h4, d); chk("R10 old enable used", d, 32'h3);
    pulse(1, 1);
    rd_reg(4'h4, d); chk("R10 then stopped", d, 32'h3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regmap();
    t_preset();
    t_fast_count();
    t_slow_count();
    t_disable();
    t_load_enabled();
    t_latency_and_zero();
    t_periodic();
    t_irq_hold();
    t_free();
    t_readonly();
    t_clear_race();
    t_ctrl_timing();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule